// File: doc/BRIEF.md
# Sampling Delay Tuning Engine

This block finds a good sampling point for a receive path by brute force. After a start pulse it steps an 8-bit delay setting through every value from 0 to 255. For each value it places the setting into one byte field of a 32-bit delay word, drives that word out, and raises a request so an outside agent can run a test transfer. The agent answers with a one-cycle completion pulse and a pass or fail bit. Once every value has been tried, the engine picks the middle of the longest unbroken stretch of passing settings. It then writes that value into the chosen field of the delay word.

A mode input, sampled at start, selects the field being tuned: the command delay byte or the rising-edge read delay byte. While a sweep runs, a 4-bit compensation-enable output is forced to zero so that delay tracking cannot disturb the swept settings. The search keeps only running counters and stores no per-step result table. If no setting passes, the engine raises an error flag instead of giving a result.

Top module: `dly_tune_engine`

## Requirements
- R1: A start_i pulse while idle launches one sweep that issues exactly 256 test requests (test_req_o high), one per delay value, in ascending order 0,1,...,255.
- R2: During the sweep the driven delay word equals the initial word captured at start, except for the swept value: in bits 15:8 when mode_i was 0 (command field), or in bits 23:16 when mode_i was 1 (read field).
- R3: While test_req_o is high and test_done_i is low, dly_word_o does not change from one cycle to the next.
- R4: comp_en_o is 4'hF after reset, becomes 4'h0 before the first test request of a sweep, and stays 4'h0 after the sweep ends.
- R5: The chosen window is the longest run of consecutive passing values, and a run that is still open at value 255 counts as a window.
- R6: When two windows have the same length, the earlier (lower) one is chosen.
- R7: The best value is window_end - (window_length - 1) / 2, using integer division.
- R8: If no value passes, done_o and err_o both go high, best_o is 0 and dly_word_o goes back to the captured initial word.
- R9: On success done_o is high, err_o is low, best_o holds the chosen value, and dly_word_o is the initial word with only the selected field replaced by that value.
- R10: start_i pulses and changes on mode_i and init_word_i while a sweep is running do not affect that sweep or its result.
- R11: After reset done_o, err_o, test_req_o and best_o are 0 and dly_word_o is 32'h0.
- R12: done_o and err_o stay set until the next accepted start clears them, and test_req_o stays low while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mode_i | input | 1 | Field select: 0 command byte [15:8], 1 read byte [23:16] |
| init_word_i | input | 32 | Initial delay word, captured at start |
| test_done_i | input | 1 | One-cycle completion of the requested test |
| test_pass_i | input | 1 | Test result, valid with test_done_i |
| test_req_o | output | 1 | Test request for the delay word now being driven |
| dly_word_o | output | 32 | Delay word driven to the sampling logic |
| comp_en_o | output | 4 | Delay compensation enables, zero once tuning starts |
| best_o | output | 8 | Chosen delay value |
| done_o | output | 1 | Sweep finished |
| err_o | output | 1 | No passing value was found |

## Verification
The hardest case is when the last test response closes a window in the same cycle that ends the sweep. The run that reaches value 255 must be compared against the best window found so far at the moment the sweep stops, and it must not be dropped. The bench sets this up with pass patterns whose longest run ends at 255, one of them in read mode. It also uses an all-pass pattern, where the only window both opens at 0 and closes at 255. Each result is compared against a window search that the bench computes separately, using a close-on-fail method.

// File: rtl/dly_tune_pkg.sv
package dly_tune_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINAL  = 2'd3
  } tune_state_t;
endpackage

// File: rtl/dly_sweep_ctrl.sv
module dly_sweep_ctrl #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             test_done_i,
  output logic [DLY_W-1:0] idx_o,
  output logic             launch_o,
  output logic             settle_o,
  output logic             step_o,
  output logic             req_o,
  output logic             finish_o
);
  import dly_tune_pkg::*;

  localparam logic [DLY_W-1:0] LAST_IDX = {DLY_W{1'b1}};

  tune_state_t      state_q, state_d;
  logic [DLY_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SETTLE;
          idx_d   = '0;
        end
      end
      ST_SETTLE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (test_done_i) begin
          if (idx_q == LAST_IDX) begin
            state_d = ST_FINAL;
          end else begin
            state_d = ST_SETTLE;
            idx_d   = idx_q + 1'b1;
          end
        end
      end
      ST_FINAL: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign idx_o    = idx_q;
  assign launch_o = (state_q == ST_IDLE) && start_i;
  assign settle_o = (state_q == ST_SETTLE);
  assign step_o   = (state_q == ST_WAIT) && test_done_i;
  assign req_o    = (state_q == ST_WAIT);
  assign finish_o = (state_q == ST_FINAL);

  // R1: each accepted step moves to the next delay value
  p_idx_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && idx_q != LAST_IDX) |=> (idx_q == $past(idx_q) + 1'b1));

  // R1: the sweep ends only after the last value was tested
  p_final_after_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(finish_o) |-> (idx_q == LAST_IDX));
endmodule

// File: rtl/dly_win_track.sv
module dly_win_track #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             pass_i,
  input  logic [DLY_W-1:0] idx_i,
  output logic [DLY_W:0]   best_len_o,
  output logic [DLY_W-1:0] centre_o
);
  logic [DLY_W:0]   run_q, run_d;
  logic [DLY_W:0]   blen_q, blen_d;
  logic [DLY_W-1:0] bend_q, bend_d;
  logic [DLY_W:0]   run_inc;
  logic [DLY_W:0]   half_len;

  assign run_inc = run_q + 1'b1;

  always_comb begin
    run_d  = run_q;
    blen_d = blen_q;
    bend_d = bend_q;
    if (clear_i) begin
      run_d  = '0;
      blen_d = '0;
      bend_d = '0;
    end else if (step_i) begin
      if (pass_i) begin
        run_d = run_inc;
        if (run_inc > blen_q) begin
          blen_d = run_inc;
          bend_d = idx_i;
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      blen_q <= '0;
      bend_q <= '0;
    end else begin
      run_q  <= run_d;
      blen_q <= blen_d;
      bend_q <= bend_d;
    end
  end

  assign half_len   = (blen_q == '0) ? '0 : ((blen_q - 1'b1) >> 1);
  assign best_len_o = blen_q;
  assign centre_o   = bend_q - half_len[DLY_W-1:0];

  // R5: the best length only grows within a sweep
  p_best_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (blen_q >= $past(blen_q)));

  // R5: the current run never exceeds the best run
  p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= blen_q);
endmodule

// File: rtl/dly_field_merge.sv
module dly_field_merge #(
  parameter int WORD_W   = 32,
  parameter int DLY_W    = 8,
  parameter int CMD_LSB  = 8,
  parameter int DATA_LSB = 16
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              sel_data_i,
  input  logic [DLY_W-1:0]  val_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o = word_i;
    if (sel_data_i) word_o[DATA_LSB +: DLY_W] = val_i;
    else            word_o[CMD_LSB  +: DLY_W] = val_i;
  end
endmodule

// File: rtl/dly_tune_engine.sv
module dly_tune_engine #(
  parameter int WORD_W   = 32,
  parameter int DLY_W    = 8,
  parameter int CMD_LSB  = 8,
  parameter int DATA_LSB = 16,
  parameter int COMP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [WORD_W-1:0] init_word_i,
  input  logic              test_done_i,
  input  logic              test_pass_i,
  output logic              test_req_o,
  output logic [WORD_W-1:0] dly_word_o,
  output logic [COMP_W-1:0] comp_en_o,
  output logic [DLY_W-1:0]  best_o,
  output logic              done_o,
  output logic              err_o
);
  logic              launch, settle, step, finish;
  logic [DLY_W-1:0]  idx;
  logic [DLY_W:0]    best_len;
  logic [DLY_W-1:0]  centre;
  logic [WORD_W-1:0] sweep_word, final_word;

  logic [WORD_W-1:0] init_q, init_d;
  logic              mode_q, mode_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [COMP_W-1:0] comp_q, comp_d;
  logic [DLY_W-1:0]  best_q, best_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  dly_sweep_ctrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .test_done_i(test_done_i),
    .idx_o(idx), .launch_o(launch), .settle_o(settle), .step_o(step),
    .req_o(test_req_o), .finish_o(finish)
  );

  dly_win_track #(.DLY_W(DLY_W)) u_track (
    .clk(clk), .rst_n(rst_n), .clear_i(launch), .step_i(step),
    .pass_i(test_pass_i), .idx_i(idx), .best_len_o(best_len), .centre_o(centre)
  );

  dly_field_merge #(.WORD_W(WORD_W), .DLY_W(DLY_W), .CMD_LSB(CMD_LSB),
                    .DATA_LSB(DATA_LSB)) u_sweep_merge (
    .word_i(init_q), .sel_data_i(mode_q), .val_i(idx), .word_o(sweep_word)
  );

  dly_field_merge #(.WORD_W(WORD_W), .DLY_W(DLY_W), .CMD_LSB(CMD_LSB),
                    .DATA_LSB(DATA_LSB)) u_final_merge (
    .word_i(init_q), .sel_data_i(mode_q), .val_i(centre), .word_o(final_word)
  );

  always_comb begin
    init_d = init_q;
    mode_d = mode_q;
    word_d = word_q;
    comp_d = comp_q;
    best_d = best_q;
    done_d = done_q;
    err_d  = err_q;
    if (launch) begin
      init_d = init_word_i;
      mode_d = mode_i;
      comp_d = '0;
      best_d = '0;
      done_d = 1'b0;
      err_d  = 1'b0;
    end
    if (settle) word_d = sweep_word;
    if (finish) begin
      done_d = 1'b1;
      if (best_len == '0) begin
        err_d  = 1'b1;
        best_d = '0;
        word_d = init_q;
      end else begin
        best_d = centre;
        word_d = final_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
      mode_q <= 1'b0;
      word_q <= '0;
      comp_q <= '1;
      best_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      init_q <= init_d;
      mode_q <= mode_d;
      word_q <= word_d;
      comp_q <= comp_d;
      best_q <= best_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign dly_word_o = word_q;
  assign comp_en_o  = comp_q;
  assign best_o     = best_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

  // R3: word held while a test is outstanding
  p_word_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req_o && !test_done_i) |=> $stable(dly_word_o));

  // R4: compensation is off whenever a test is requested
  p_comp_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    test_req_o |-> (comp_en_o == '0));

  // R8: error only comes with done
  p_err_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  // R12: no request while the result is presented
  p_done_no_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !test_req_o);

  // R12: result flags hold until a new sweep is launched
  p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(best_o) && $stable(err_o)));
endmodule

// File: tb/dly_tune_engine_test.sv
module dly_tune_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, mode_i, test_done_i, test_pass_i;
  logic [31:0] init_word_i;
  logic        test_req_o, done_o, err_o;
  logic [31:0] dly_word_o;
  logic [3:0]  comp_en_o;
  logic [7:0]  best_o;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic        err;
    logic [7:0]  best;
    logic [31:0] word;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [255:0] pat;
  logic        cur_mode;
  logic [31:0] cur_init;
  int          req_cnt;
  int          field_bad;
  int          order_bad;
  int          comp_bad;
  int          results_seen = 0;

  dly_tune_engine uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .init_word_i(init_word_i), .test_done_i(test_done_i), .test_pass_i(test_pass_i),
    .test_req_o(test_req_o), .dly_word_o(dly_word_o), .comp_en_o(comp_en_o),
    .best_o(best_o), .done_o(done_o), .err_o(err_o)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] put_field(logic [31:0] w, logic m, logic [7:0] v);
    logic [31:0] r;
    r = w;
    if (m) r[23:16] = v;
    else   r[15:8]  = v;
    return r;
  endfunction

  // Close-on-fail window search, written independently of the design
  function automatic exp_t model(logic [255:0] p, logic m, logic [31:0] w);
    exp_t e;
    int blen, bend, cur;
    blen = 0; bend = 0; cur = 0;
    for (int i = 0; i < 256; i++) begin
      if (p[i]) cur++;
      if (!p[i] || i == 255) begin
        if (cur > blen) begin
          blen = cur;
          bend = p[i] ? i : i - 1;
        end
        cur = 0;
      end
    end
    if (blen == 0) begin
      e.err = 1'b1; e.best = 8'd0; e.word = w;
    end else begin
      e.err = 1'b0;
      e.best = 8'(bend - (blen - 1) / 2);
      e.word = put_field(w, m, e.best);
    end
    return e;
  endfunction

  // Requester: answers each request with the pattern bit for the expected index
  initial begin
    test_done_i = 1'b0;
    test_pass_i = 1'b0;
    forever begin
      @(negedge clk);
      if (test_req_o) begin
        logic [31:0] seen;
        seen = dly_word_o;
        if (req_cnt == 0 && comp_en_o != 4'h0) comp_bad++;
        if (seen !== put_field(cur_init, cur_mode, 8'(req_cnt))) field_bad++;
        if ((cur_mode ? seen[23:16] : seen[15:8]) != 8'(req_cnt)) order_bad++;
        repeat (req_cnt % 3) begin
          @(negedge clk);
          if (dly_word_o !== seen) field_bad++;
        end
        test_done_i = 1'b1;
        test_pass_i = pat[req_cnt % 256];
        req_cnt++;
        @(negedge clk);
        test_done_i = 1'b0;
        test_pass_i = 1'b0;
      end
    end
  end

  // Monitor: pops expected result when done rises
  initial begin
    forever begin
      exp_t e;
      @(posedge done_o);
      @(negedge clk);
      results_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected result", 32'(best_o), 32'h0);
      end else begin
        e = exp_q.pop_front();
        check(err_o == e.err, e.tag, "err_o", 32'(err_o), 32'(e.err));
        check(best_o == e.best, e.tag, "best_o", 32'(best_o), 32'(e.best));
        check(dly_word_o == e.word, e.tag, "dly_word_o", dly_word_o, e.word);
        check(!test_req_o, "R12", "req low at done", 32'(test_req_o), 32'h0);
      end
    end
  end

  task automatic run_case(input logic m, input logic [31:0] w, input logic [255:0] p,
                          input string tag, input bit poke);
    exp_t e;
    pat = p; cur_mode = m; cur_init = w;
    req_cnt = 0; field_bad = 0; order_bad = 0; comp_bad = 0;
    e = model(p, m, w);
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    start_i = 1'b1; mode_i = m; init_word_i = w;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b0 && err_o == 1'b0, "R12", "flags cleared by start",
          {30'h0, done_o, err_o}, 32'h0);
    if (poke) begin
      repeat (40) @(negedge clk);
      mode_i = ~m; init_word_i = ~w; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (300) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait (done_o);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9", "result delivered", 32'(exp_q.size()), 32'h0);
    check(req_cnt == 256, "R1", "request count", 32'(req_cnt), 32'd256);
    check(order_bad == 0, "R1", "ascending order errors", 32'(order_bad), 32'h0);
    check(field_bad == 0, "R2", "field/stability errors (R3)", 32'(field_bad), 32'h0);
    check(comp_bad == 0, "R4", "comp before first request", 32'(comp_bad), 32'h0);
    check(comp_en_o == 4'h0, "R4", "comp after sweep", 32'(comp_en_o), 32'h0);
    check(done_o, "R12", "done held", 32'(done_o), 32'h1);
  endtask

  initial begin
    logic [255:0] p;
    rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0; init_word_i = 32'h0;
    pat = '0; cur_mode = 1'b0; cur_init = '0; req_cnt = 0;
    field_bad = 0; order_bad = 0; comp_bad = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!done_o && !err_o && !test_req_o, "R11", "flags after reset",
          {29'h0, done_o, err_o, test_req_o}, 32'h0);
    check(dly_word_o == 32'h0 && best_o == 8'h0, "R11", "word/best after reset",
          dly_word_o, 32'h0);
    check(comp_en_o == 4'hF, "R4", "comp after reset", 32'(comp_en_o), 32'hF);

    // R8: nothing passes
    run_case(1'b0, 32'hA5C3_7E19, '0, "R8", 1'b0);
    // R5/R7/R9: all pass, window spans 0..255
    run_case(1'b0, 32'h1234_5678, '1, "R7", 1'b0);
    // R9: single pass at value 0
    p = '0; p[0] = 1'b1;
    run_case(1'b1, 32'hFFFF_FFFF, p, "R9", 1'b0);
    // R6: equal windows 10..19 and 100..109
    p = '0; p[19:10] = '1; p[109:100] = '1;
    run_case(1'b0, 32'h0F0F_0F0F, p, "R6", 1'b0);
    // R5: open run at the end 250..255 beats 20..24, read field
    p = '0; p[24:20] = '1; p[255:250] = '1;
    run_case(1'b1, 32'hC0DE_BEEF, p, "R5", 1'b0);
    // R7: later longer window 60..69 over 30..33, even length
    p = '0; p[33:30] = '1; p[69:60] = '1; p[200] = 1'b1;
    run_case(1'b0, 32'h8001_0002, p, "R7", 1'b0);
    // R10: start/mode/word disturbed mid sweep
    p = '0; p[140:128] = '1; p[7:3] = '1;
    run_case(1'b1, 32'h5A5A_A5A5, p, "R10", 1'b1);
    check(results_seen == 7, "R10", "result count", 32'(results_seen), 32'd7);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule